// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers up to 32 interrupt sources into one memory-mapped bank and drives a single level interrupt. A one-cycle pulse on a source input latches a sticky cause bit. Software reads the cause either raw or filtered through the mask. A per-bit control register decides how each cause bit is acknowledged: by writing a one to it, or automatically when a read returns it. Software can also raise causes itself. It can change mask bits atomically through dedicated set and clear addresses, or rewrite the whole mask directly.

The bank is reached through a simple word-wide port with separate read and write strobes and a byte offset. Read data is registered: it appears on `rdata_o` one cycle after the read strobe and is held until the next read. Any clearing that the read causes takes effect at that same edge. Bit k of every register belongs to source k. A set mask bit hides its source from the masked view and from the interrupt output.

Top module: `intr_cause_bank`

## Requirements
- R1: Registers sit at byte offsets 0x00 control, 0x04 cause, 0x08 masked cause, 0x0C cause-set, 0x10 mask, 0x14 mask-set, 0x18 mask-clear. Offset bits [1:0] are ignored. Read data for a read strobed at edge n is on `rdata_o` after edge n and is held until the next read.
- R2: After reset, cause and control read 0, the mask reads 0xFFFFFFFF and `irq_o` is 0.
- R3: A pulse on `evt_i[k]` sets cause bit k. A read strobed on the following cycle returns it.
- R4: When control bit k is 0, writing 1 to cause bit k clears it, writing 0 leaves it, and reads never clear it.
- R5: When control bit k is 1, a read of the cause register clears bit k if that read returned it set. Writes to the cause register leave bit k unchanged.
- R6: The masked-cause offset reads cause AND NOT mask. Writes there clear bits under rule R4. A read there clears, under rule R5, only bits that the read returned as 1.
- R7: Writing 1 to a bit of cause-set sets that cause bit. Zero bits leave the cause unchanged.
- R8: The mask offset is read/write. Ones written to mask-set set mask bits, and ones written to mask-clear clear them. Zero bits leave the mask unchanged.
- R9: `irq_o` is registered. After every edge it equals the OR of (cause AND NOT mask) held after that edge.
- R10: A source pulse and a software clear of the same bit in the same cycle leave the bit set.
- R11: Reads of cause-set, mask-set, mask-clear and offset 0x1C return 0. Writes to 0x1C change nothing.
- R12: The control register is read/write and holds the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NSRC | Source event pulses, one per cause bit |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | AW | Byte offset within the bank |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
Every state change happens at the edge that samples the strobe or pulse. Read data and `irq_o` therefore become visible one edge after the stimulus, and a read issued in the next cycle already sees an event or a write. The bench drives inputs on the falling edge and keeps a behavioural model of cause, mask and control that it updates at the rising edge. On every falling edge it compares `irq_o` and the held read data against that model. Directed reads also compare against constants derived from the requirements, so that the clear-on-read, write-one-to-clear and set-wins cases are each pinned to a known value one cycle after their strobe.

// File: rtl/intr_bank_pkg.sv
package intr_bank_pkg;
  localparam int OFF_CTL    = 0;
  localparam int OFF_CAUSE  = 1;
  localparam int OFF_MCAUSE = 2;
  localparam int OFF_CSET   = 3;
  localparam int OFF_MVAL   = 4;
  localparam int OFF_MSET   = 5;
  localparam int OFF_MCLR   = 6;
  localparam int NUM_REGS   = 7;

  typedef struct packed {
    logic mclr;
    logic mset;
    logic mval;
    logic cset;
    logic mcause;
    logic cause;
    logic ctl;
  } reg_hit_t;
endpackage

// File: rtl/intr_decode.sv
module intr_decode
  import intr_bank_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output reg_hit_t      hit_o
);
  localparam int IW = AW - 2;

  logic [NUM_REGS-1:0] hit_vec;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
    assign hit_vec[k] = en_i && (addr_i[AW-1:2] == IW'(k));
  end

  assign hit_o = reg_hit_t'(hit_vec);
endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg #(
  parameter int NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_ctl_i,
  input  logic            wr_mval_i,
  input  logic            wr_mset_i,
  input  logic            wr_mclr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] ctl_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] mask_next_o
);
  logic [NSRC-1:0] ctl_q, mask_q;

  always_comb begin
    mask_next_o = mask_q;
    if (wr_mval_i) mask_next_o = wdata_i;
    if (wr_mset_i) mask_next_o = mask_q | wdata_i;
    if (wr_mclr_i) mask_next_o = mask_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      mask_q <= '1;
    end else begin
      if (wr_ctl_i) ctl_q <= wdata_i;
      mask_q <= mask_next_o;
    end
  end

  assign ctl_o  = ctl_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/intr_cause_reg.sv
module intr_cause_reg #(
  parameter int NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] ctl_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            wr_cause_i,
  input  logic            wr_mcause_i,
  input  logic            wr_cset_i,
  input  logic            rd_cause_i,
  input  logic            rd_mcause_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] cause_o,
  output logic [NSRC-1:0] cause_next_o
);
  logic [NSRC-1:0] cause_q, w1c_clr, cor_clr, sw_set;

  // write-clear only on bits in write-one-to-clear mode
  assign w1c_clr = (wr_cause_i || wr_mcause_i) ? (wdata_i & ~ctl_i) : '0;
  // read-clear only on bits the read actually returned
  assign cor_clr = ctl_i & ((rd_cause_i  ? cause_q           : '0) |
                            (rd_mcause_i ? (cause_q & ~mask_i) : '0));
  assign sw_set  = wr_cset_i ? wdata_i : '0;

  // sets applied last: a concurrent event always survives
  assign cause_next_o = (cause_q & ~(w1c_clr | cor_clr)) | sw_set | evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_next_o;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/intr_cause_bank.sv
module intr_cause_bank
  import intr_bank_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  reg_hit_t        wr_hit, rd_hit;
  logic [NSRC-1:0] wdata_src;
  logic [NSRC-1:0] ctl_q, mask_q, mask_next, cause_q, cause_next;
  logic [NSRC-1:0] rd_src;
  logic [DW-1:0]   rd_word;
  logic [DW-1:0]   rdata_q;
  logic            irq_q;

  assign wdata_src = wdata_i[NSRC-1:0];

  intr_decode #(.AW(AW)) u_wr_dec (.en_i(wr_en_i), .addr_i(addr_i), .hit_o(wr_hit));
  intr_decode #(.AW(AW)) u_rd_dec (.en_i(rd_en_i), .addr_i(addr_i), .hit_o(rd_hit));

  intr_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctl_i    (wr_hit.ctl),
    .wr_mval_i   (wr_hit.mval),
    .wr_mset_i   (wr_hit.mset),
    .wr_mclr_i   (wr_hit.mclr),
    .wdata_i     (wdata_src),
    .ctl_o       (ctl_q),
    .mask_o      (mask_q),
    .mask_next_o (mask_next)
  );

  intr_cause_reg #(.NSRC(NSRC)) u_cause (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt_i),
    .ctl_i        (ctl_q),
    .mask_i       (mask_q),
    .wr_cause_i   (wr_hit.cause),
    .wr_mcause_i  (wr_hit.mcause),
    .wr_cset_i    (wr_hit.cset),
    .rd_cause_i   (rd_hit.cause),
    .rd_mcause_i  (rd_hit.mcause),
    .wdata_i      (wdata_src),
    .cause_o      (cause_q),
    .cause_next_o (cause_next)
  );

  always_comb begin
    rd_src = '0;
    unique case (1'b1)
      rd_hit.ctl:    rd_src = ctl_q;
      rd_hit.cause:  rd_src = cause_q;
      rd_hit.mcause: rd_src = cause_q & ~mask_q;
      rd_hit.mval:   rd_src = mask_q;
      default:       rd_src = '0;
    endcase
  end

  if (NSRC < DW) begin : g_pad
    assign rd_word = {{(DW-NSRC){1'b0}}, rd_src};
  end else begin : g_full
    assign rd_word = rd_src;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= rd_word;
      irq_q <= |(cause_next & ~mask_next);
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/intr_cause_bank_chk.sv
module intr_cause_bank_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] evt_i,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   rdata_o,
  input logic            irq_o,
  input logic [NSRC-1:0] cause_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] ctl_q
);
  logic [AW-3:0] idx;
  assign idx = addr_i[AW-1:2];

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i))); // R10

  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(cause_q & ~mask_q)); // R9

  AST_MSET_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx == 5) |=> ((mask_q & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0]))); // R8

  AST_MCLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx == 6) |=> ((mask_q & $past(wdata_i[NSRC-1:0])) == '0)); // R8

  AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (idx == 3 || idx == 5 || idx == 6 || idx == 7)) |=> (rdata_o == '0)); // R11

  AST_COR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && idx == 1 && !wr_en_i && evt_i == '0) |=> ((cause_q & $past(cause_q & ctl_q)) == '0)); // R5
endmodule

bind intr_cause_bank intr_cause_bank_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cause_q (cause_q),
  .mask_q  (mask_q),
  .ctl_q   (ctl_q)
);

// File: tb/sim_intr_cause_bank.sv
`timescale 1ns/1ps
module sim_intr_cause_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  logic [31:0] m_cause, m_mask, m_ctl, m_rdata;
  logic        m_irq;

  always #4 clk_i = ~clk_i;

  intr_cause_bank u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cause = '0; m_mask = '1; m_ctl = '0; m_rdata = '0; m_irq = 1'b0;
    end else begin
      int idx;
      logic [31:0] nc, nm, nctl, w;
      idx  = int'(addr_i) / 4;
      w    = wdata_i;
      nc   = m_cause; nm = m_mask; nctl = m_ctl;
      if (rd_en_i) begin
        case (idx)
          0: m_rdata = m_ctl;
          1: begin m_rdata = m_cause; nc = nc & ~(m_cause & m_ctl); end
          2: begin m_rdata = m_cause & ~m_mask; nc = nc & ~(m_cause & ~m_mask & m_ctl); end
          4: m_rdata = m_mask;
          default: m_rdata = '0;
        endcase
      end
      if (wr_en_i) begin
        case (idx)
          0: nctl = w;
          1, 2: nc = nc & ~(w & ~m_ctl);
          4: nm = w;
          5: nm = m_mask | w;
          6: nm = m_mask & ~w;
          default: ;
        endcase
      end
      nc = nc | evt_i;
      if (wr_en_i && idx == 3) nc = nc | w;
      m_cause = nc; m_mask = nm; m_ctl = nctl;
      m_irq = |(nc & ~nm);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R9 irq_o vs model", {31'b0, irq_o}, {31'b0, m_irq});
      chk("R1 rdata_o vs model", rdata_o, m_rdata);
    end
  end

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [31:0] ev = '0);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; evt_i = ev;
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk_i);
    evt_i = ev;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    chk("R2 irq at reset", {31'b0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    rd(5'h00, v); chk("R2 ctl reset", v, 32'h0);
    rd(5'h10, v); chk("R2 mask reset", v, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R2 cause reset", v, 32'h0);

    pulse(32'h5);
    rd(5'h04, v); chk("R3 event latched", v, 32'h5);
    rd(5'h04, v); chk("R4 read does not clear w1c", v, 32'h5);
    chk("R9 masked source no irq", {31'b0, irq_o}, 32'd0);
    rd(5'h08, v); chk("R6 masked view all masked", v, 32'h0);

    wr(5'h18, 32'h1);
    rd(5'h10, v); chk("R8 mask-clear", v, 32'hFFFF_FFFE);
    chk("R9 irq raised", {31'b0, irq_o}, 32'd1);
    rd(5'h08, v); chk("R6 masked view", v, 32'h1);
    wr(5'h04, 32'h4);
    rd(5'h04, v); chk("R4 w1c on cause", v, 32'h1);
    wr(5'h08, 32'h1);
    rd(5'h04, v); chk("R6 w1c via masked view", v, 32'h0);
    chk("R9 irq dropped", {31'b0, irq_o}, 32'd0);

    wr(5'h00, 32'hF0);
    rd(5'h00, v); chk("R12 ctl readback", v, 32'hF0);
    wr(5'h0C, 32'h30);
    rd(5'h04, v); chk("R7 cause-set", v, 32'h30);
    rd(5'h04, v); chk("R5 clear on read", v, 32'h0);
    wr(5'h0C, 32'h30);
    wr(5'h04, 32'h30);
    rd(5'h04, v); chk("R5 write ignored on cor bits", v, 32'h30);
    rd(5'h04, v); chk("R5 cleared after read", v, 32'h0);
    wr(5'h0C, 32'h30);
    wr(5'h18, 32'h10);
    rd(5'h08, v); chk("R6 cor via masked view", v, 32'h10);
    rd(5'h04, v); chk("R6 unreturned bit kept", v, 32'h20);
    rd(5'h04, v); chk("R5 all cleared", v, 32'h0);

    wr(5'h10, 32'h1234_5678);
    rd(5'h10, v); chk("R8 mask write", v, 32'h1234_5678);
    wr(5'h14, 32'h1);
    rd(5'h10, v); chk("R8 mask-set", v, 32'h1234_5679);
    wr(5'h10, 32'hFFFF_FFFF);

    wr(5'h0C, 32'h2);
    wr(5'h04, 32'h2, 32'h2);
    rd(5'h04, v); chk("R10 event beats clear", v, 32'h2);
    wr(5'h04, 32'h2);
    rd(5'h04, v); chk("R4 cleared later", v, 32'h0);

    rd(5'h0C, v); chk("R11 cause-set reads zero", v, 32'h0);
    rd(5'h14, v); chk("R11 mask-set reads zero", v, 32'h0);
    rd(5'h18, v); chk("R11 mask-clear reads zero", v, 32'h0);
    wr(5'h1C, 32'h0);
    rd(5'h1C, v); chk("R11 unused offset reads zero", v, 32'h0);
    rd(5'h10, v); chk("R11 unused write no effect", v, 32'hFFFF_FFFF);

    repeat (2) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule